// File: doc/BRIEF.md
# Calibration Status and End-of-Scan Interrupt Gate

This block sits beside the conversion sequencer of a multi-channel converter. Two per-channel vectors come in: one marks which logical channels are enabled, and one marks which channels are running a calibration. The block reduces them to a single calibration-active status output. Only a channel that is both enabled and calibrating counts. A suppress-enable bit in the control word uses this status to decide whether a raw scan-complete pulse may raise the end-of-scan interrupt.

The interrupt is a level output. A scan-complete pulse sets it, and a host acknowledge clears it. While the host holds the calibration-memory access strobe, the block keeps the sequencer halted. The halt also resets the modulator and filter state, and the interrupt is forced low. When the strobe drops, the block issues a one-cycle restart request, which tells the sequencer to begin again at the first logical channel. The control word is only an input here, so the block never alters it.

Top module: `cal_status_gate`

## Requirements
- R1: `cal_active` goes high in the cycle after any channel has both its `chan_active` bit and its `chan_cal_busy` bit set.
- R2: A channel that is calibrating but not enabled (its `chan_active` bit is 0) never raises `cal_active`, and never suppresses the interrupt.
- R3: When bit 12 of `ctrl_word` is 0, a `scan_done` pulse sets `eos_irq` in the next cycle, whatever the calibration state and the other control bits are.
- R4: When bit 12 of `ctrl_word` is 1 and some enabled channel is calibrating in the cycle of a `scan_done` pulse, `eos_irq` stays low.
- R5: When bit 12 of `ctrl_word` is 1 and no enabled channel is calibrating, a `scan_done` pulse sets `eos_irq` in the next cycle.
- R6: `eos_irq` stays high until `irq_ack` is seen, and then clears in the next cycle. If `scan_done` (not suppressed) and `irq_ack` arrive in the same cycle, the interrupt stays set.
- R7: While `calmem_access` is high, `eos_irq` is cleared in the next cycle, and `scan_done` pulses are ignored.
- R8: `conv_halt` is high from the cycle after `calmem_access` rises until the cycle after it falls.
- R9: `seq_restart` is a single-cycle pulse in the cycle after `calmem_access` falls, and it tells the sequencer to restart at the first logical channel.
- R10: During and right after reset, `cal_active`, `eos_irq`, `conv_halt` and `seq_restart` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_active | input | NUM_CH | Enabled-channel mask |
| chan_cal_busy | input | NUM_CH | Per-channel calibration-in-progress flags |
| ctrl_word | input | CTRL_W | Control word; bit SUP_BIT (12) is the suppress enable |
| scan_done | input | 1 | Raw one-cycle scan-complete pulse |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| calmem_access | input | 1 | High while the host accesses calibration memory |
| cal_active | output | 1 | An enabled channel is calibrating |
| eos_irq | output | 1 | Gated end-of-scan interrupt level |
| conv_halt | output | 1 | Stop conversion and reset the modulator and filter |
| seq_restart | output | 1 | One-cycle request to restart at the first channel |

## Verification
The assertions check on every cycle that:
- the halt output follows the access strobe with one cycle of delay;
- the interrupt is never high while the halt is active;
- the restart pulse lasts one cycle and only comes at the end of a halt;
- a suppressed scan pulse cannot raise the interrupt;
- the status output tracks the masked calibration flags.

Only the bench's scenarios can show the following: an inactive calibrating channel has no effect, the other control bits have no effect, acknowledge and set in the same cycle keep the interrupt high, and scan pulses inside an access window are dropped.

// File: rtl/cal_status_gate_pkg.sv
package cal_status_gate_pkg;

   typedef struct packed {
      logic halt;
      logic restart;
   } seq_ctrl_t;

   localparam int unsigned DEF_NUM_CH  = 8;
   localparam int unsigned DEF_CTRL_W  = 24;
   localparam int unsigned DEF_SUP_BIT = 12;

endpackage

// File: rtl/calsts_reduce.sv
module calsts_reduce #(
   parameter int unsigned NUM_CH     = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] active_mask,
   input  logic [NUM_CH-1:0] cal_busy,
   output logic              any_now,
   output logic              status
);

   logic [NUM_CH-1:0] qualified;

   assign qualified = active_mask & cal_busy;
   assign any_now   = |qualified;

   generate
      if (REGISTERED) begin : g_reg
         logic status_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_q <= 1'b0;
            else        status_q <= any_now;
         end
         assign status = status_q;
      end else begin : g_comb
         assign status = any_now & rst_n;
      end
   endgenerate

endmodule

// File: rtl/eos_gate.sv
module eos_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic scan_pulse,
   input  logic ack,
   input  logic flush,
   input  logic suppress_en,
   input  logic any_cal,
   output logic irq
);

   logic irq_q;
   logic blocked;
   logic irq_d;

   assign blocked = suppress_en & any_cal;

   always_comb begin
      irq_d = irq_q;
      if (flush)                       irq_d = 1'b0;
      else if (scan_pulse && !blocked) irq_d = 1'b1;
      else if (ack)                    irq_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= irq_d;
   end

   assign irq = irq_q;

endmodule

// File: rtl/calmem_seq.sv
module calmem_seq
   import cal_status_gate_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      access,
   output seq_ctrl_t ctl
);

   logic access_q;
   logic restart_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         access_q  <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         access_q  <= access;
         restart_q <= access_q & ~access;
      end
   end

   assign ctl.halt    = access_q;
   assign ctl.restart = restart_q;

endmodule

// File: rtl/cal_status_gate.sv
module cal_status_gate
   import cal_status_gate_pkg::*;
#(
   parameter int unsigned NUM_CH     = DEF_NUM_CH,
   parameter int unsigned CTRL_W     = DEF_CTRL_W,
   parameter int unsigned SUP_BIT    = DEF_SUP_BIT,
   parameter bit          STATUS_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] chan_active,
   input  logic [NUM_CH-1:0] chan_cal_busy,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic              scan_done,
   input  logic              irq_ack,
   input  logic              calmem_access,
   output logic              cal_active,
   output logic              eos_irq,
   output logic              conv_halt,
   output logic              seq_restart
);

   initial begin
      assert (NUM_CH >= 1) else $error("NUM_CH must be at least 1");
      assert (SUP_BIT < CTRL_W) else $error("SUP_BIT outside control word");
   end

   logic      any_cal;
   logic      ctrl_unused;
   seq_ctrl_t seq_ctl;

   assign ctrl_unused = ^ctrl_word;

   calsts_reduce #(
      .NUM_CH     (NUM_CH),
      .REGISTERED (STATUS_REG)
   ) u_reduce (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_mask (chan_active),
      .cal_busy    (chan_cal_busy),
      .any_now     (any_cal),
      .status      (cal_active)
   );

   eos_gate u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .scan_pulse  (scan_done),
      .ack         (irq_ack),
      .flush       (calmem_access),
      .suppress_en (ctrl_word[SUP_BIT]),
      .any_cal     (any_cal),
      .irq         (eos_irq)
   );

   calmem_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .access (calmem_access),
      .ctl    (seq_ctl)
   );

   assign conv_halt   = seq_ctl.halt;
   assign seq_restart = seq_ctl.restart;

endmodule

// File: rtl/cal_status_gate_chk.sv
module cal_status_gate_chk #(
   parameter int unsigned NUM_CH     = 8,
   parameter int unsigned CTRL_W     = 24,
   parameter int unsigned SUP_BIT    = 12,
   parameter bit          STATUS_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] chan_active,
   input logic [NUM_CH-1:0] chan_cal_busy,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic              scan_done,
   input logic              calmem_access,
   input logic              cal_active,
   input logic              eos_irq,
   input logic              conv_halt,
   input logic              seq_restart
);

   generate
      if (STATUS_REG) begin : g_sts
         // R1
         cal_status_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (cal_active == (|($past(chan_active) & $past(chan_cal_busy)))));
      end
   endgenerate

   // R4
   suppressed_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && ctrl_word[SUP_BIT] && |(chan_active & chan_cal_busy) && !eos_irq)
      |=> !eos_irq);

   // R7
   halt_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_halt |-> !eos_irq);

   // R8
   halt_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (conv_halt == $past(calmem_access)));

   // R9
   restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_restart |=> !seq_restart);

   // R9
   restart_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_restart |-> ($past(conv_halt) && !conv_halt));

endmodule

bind cal_status_gate cal_status_gate_chk #(
   .NUM_CH     (NUM_CH),
   .CTRL_W     (CTRL_W),
   .SUP_BIT    (SUP_BIT),
   .STATUS_REG (STATUS_REG)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .chan_active   (chan_active),
   .chan_cal_busy (chan_cal_busy),
   .ctrl_word     (ctrl_word),
   .scan_done     (scan_done),
   .calmem_access (calmem_access),
   .cal_active    (cal_active),
   .eos_irq       (eos_irq),
   .conv_halt     (conv_halt),
   .seq_restart   (seq_restart)
);

// File: tb/cal_status_gate_bench.sv
`timescale 1ns/1ps
module cal_status_gate_bench;

   localparam int NCH = 8;
   localparam int CW  = 24;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] chan_active = '0;
   logic [NCH-1:0] chan_cal_busy = '0;
   logic [CW-1:0]  ctrl_word = '0;
   logic           scan_done = 1'b0;
   logic           irq_ack = 1'b0;
   logic           calmem_access = 1'b0;
   logic           cal_active, eos_irq, conv_halt, seq_restart;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   cal_status_gate u_cal_status_gate (
      .clk           (clk),
      .rst_n         (rst_n),
      .chan_active   (chan_active),
      .chan_cal_busy (chan_cal_busy),
      .ctrl_word     (ctrl_word),
      .scan_done     (scan_done),
      .irq_ack       (irq_ack),
      .calmem_access (calmem_access),
      .cal_active    (cal_active),
      .eos_irq       (eos_irq),
      .conv_halt     (conv_halt),
      .seq_restart   (seq_restart)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic pulse_scan();
      scan_done = 1'b1;
      step();
      scan_done = 1'b0;
   endtask

   task automatic clear_irq();
      irq_ack = 1'b1;
      step();
      irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      check("R10", "cal_active at reset", cal_active, 1'b0);
      check("R10", "eos_irq at reset", eos_irq, 1'b0);
      check("R10", "conv_halt at reset", conv_halt, 1'b0);
      check("R10", "seq_restart at reset", seq_restart, 1'b0);
   endtask

   task automatic t_status();
      chan_active = 8'h01; chan_cal_busy = 8'h01; step();
      check("R1", "active channel calibrating", cal_active, 1'b1);
      chan_active = 8'h81; chan_cal_busy = 8'h80; step();
      check("R1", "highest channel calibrating", cal_active, 1'b1);
      chan_active = 8'h01; chan_cal_busy = 8'h7E; step();
      check("R2", "only inactive calibrating", cal_active, 1'b0);
      chan_active = 8'hFF; chan_cal_busy = 8'h00; step();
      check("R2", "none calibrating", cal_active, 1'b0);
   endtask

   task automatic t_no_suppress();
      ctrl_word = ~(24'h1 << 12);
      chan_active = 8'h0F; chan_cal_busy = 8'h04;
      pulse_scan();
      check("R3", "flag low sets irq", eos_irq, 1'b1);
      clear_irq();
      check("R6", "ack clears irq", eos_irq, 1'b0);
   endtask

   task automatic t_suppress();
      ctrl_word = 24'h1 << 12;
      chan_active = 8'h0F; chan_cal_busy = 8'h04;
      pulse_scan();
      check("R4", "suppressed pulse", eos_irq, 1'b0);
      step();
      check("R4", "still suppressed", eos_irq, 1'b0);
   endtask

   task automatic t_normal_with_flag();
      ctrl_word = 24'h1 << 12;
      chan_active = 8'h0F; chan_cal_busy = 8'hF0;
      pulse_scan();
      check("R5", "flag high, inactive calibrating", eos_irq, 1'b1);
      check("R2", "inactive does not suppress", eos_irq, 1'b1);
      clear_irq();
   endtask

   task automatic t_ack_hold();
      ctrl_word = '0; chan_cal_busy = '0;
      pulse_scan();
      step(); step();
      check("R6", "irq holds without ack", eos_irq, 1'b1);
      scan_done = 1'b1; irq_ack = 1'b1; step();
      scan_done = 1'b0; irq_ack = 1'b0;
      check("R6", "set wins over ack", eos_irq, 1'b1);
      clear_irq();
      check("R6", "ack clears", eos_irq, 1'b0);
   endtask

   task automatic t_access();
      ctrl_word = '0; chan_cal_busy = '0;
      pulse_scan();
      check("R7", "irq set before access", eos_irq, 1'b1);
      calmem_access = 1'b1; step();
      check("R7", "access clears irq", eos_irq, 1'b0);
      check("R8", "halt after rise", conv_halt, 1'b1);
      check("R9", "no restart while halted", seq_restart, 1'b0);
      pulse_scan();
      check("R7", "scan ignored during access", eos_irq, 1'b0);
      step();
      check("R8", "halt held", conv_halt, 1'b1);
      calmem_access = 1'b0; step();
      check("R8", "halt drops", conv_halt, 1'b0);
      check("R9", "restart pulse", seq_restart, 1'b1);
      step();
      check("R9", "restart single cycle", seq_restart, 1'b0);
      check("R7", "irq stays low after access", eos_irq, 1'b0);
   endtask

   initial begin
      #2000000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      step(); step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_status();
      t_no_suppress();
      t_suppress();
      t_normal_with_flag();
      t_ack_hold();
      t_access();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule